// File: doc/BRIEF.md
# Iterative CORDIC Sine-Cosine Generator

This block returns the cosine and sine of an angle. It uses a rotation-mode CORDIC engine that is shared in time. One shift-add datapath performs one micro-rotation per clock. Each micro-rotation turns the working vector through the angle arctan(2^-i), held in a small computed constant table. The sign of the remaining angle chooses the direction of each turn.

The gain of the micro-rotations is not corrected by a multiply at the end. Instead the starting vector is loaded already scaled by K ≈ 0.6073. Angles in the rear half-plane are first folded back by half a turn, and the starting vector is negated to compensate, so the iterations always start inside their convergence range.

The caller pulses `start_i` with an angle. After a fixed number of cycles the block pulses `done_o` for one cycle, with the results on `cos_o` and `sin_o`. The results stay there until the next result is produced.

The control is a three-state machine:
- **IDLE** moves to **ROTATE** when `start_i` is seen. On that edge it loads the folded start state.
- **ROTATE** stays in ROTATE for `ITER` micro-rotations. It moves to **FINISH** on the last one.
- **FINISH** moves to **IDLE** unconditionally. On that edge it writes the rounded results and raises `done_o`.

Top module: `sincos_rotator`

## Requirements
- R1: While reset is held and afterwards until the first result, `done_o` is 0 and `cos_o` and `sin_o` are 0.
- R2: If `start_i` is sampled high on clock edge E while the block is idle, then `done_o` is high in exactly the one cycle that follows edge E+ITER+1. With the defaults this is edge E+17.
- R3: The angle encoding is fixed as follows.
  - `angle_i` is a two's-complement binary angle in which 2^ANG_W counts are one full turn (16384 = 90°).
  - `cos_o` and `sin_o` are two's-complement values with OUT_W-2 fraction bits (16384 = 1.0).
  - For angles in [-90°, +90°), each output is within 4 LSB of the exact cosine or sine.
- R4: Angles whose two top bits differ (the range [+90°, 180°) and the range [-180°, -90°)) meet the same 4 LSB bound. This includes exactly +90° and -180°.
- R5: A `start_i` pulse that arrives while a computation is running has no effect. It changes neither the result nor the timing of the computation in progress.
- R6: `cos_o` and `sin_o` change only on the edge that raises `done_o`. At all other times they hold their values.
- R7: `done_o` is never high for two consecutive cycles.
- R8: A start given in the same cycle that `done_o` is high is accepted, so results can follow back to back every ITER+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a computation (sampled when idle) |
| angle_i | input | ANG_W | Binary angle, one turn = 2^ANG_W |
| done_o | output | 1 | One-cycle result-valid pulse |
| cos_o | output | OUT_W | Cosine, OUT_W-2 fraction bits |
| sin_o | output | OUT_W | Sine, OUT_W-2 fraction bits |

## Verification
The checker assumes the following about the inputs:
- `start_i` is a clean synchronous level.
- Any start seen while a computation is running must produce no extra `done_o`. The checker's own run tracker therefore accepts a start only when idle or in the done cycle.
- `angle_i` may take any value.

The stimulus is driven on falling edges and covers the following cases:
- every quadrant boundary and its neighbours, plus a coarse sweep of the whole turn;
- starts during busy periods;
- back-to-back starts given in the done cycle;
- idle gaps of varying length.

Because of this, every accepted start in the stimulus matches what the checker's tracker expects.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ROTATE = 2'd1,
        ST_FINISH = 2'd2
    } phase_t;

    // Limit of the product of 1/sqrt(1 + 2^-2i) for many steps
    localparam real ROT_GAIN = 0.6072529350088813;
    localparam real TWO_PI   = 6.283185307179586;

endpackage

// File: rtl/sincos_fold.sv
// Moves a full-turn binary angle into [-90, +90) degrees.
// flip_o tells the caller to negate the start vector.
module sincos_fold #(
    parameter int ANG_W = 16,
    parameter int ZG    = 2,
    localparam int ZW   = ANG_W + ZG
) (
    input  logic [ANG_W-1:0]     angle_i,
    output logic signed [ZW-1:0] z_o,
    output logic                 flip_o
);
    logic [ANG_W-1:0] folded;

    always_comb begin
        // The two top bits differ in the rear half-plane.
        flip_o = angle_i[ANG_W-1] ^ angle_i[ANG_W-2];
        folded = angle_i;
        if (flip_o) begin
            // Adding or subtracting half a turn only inverts the MSB.
            folded[ANG_W-1] = ~angle_i[ANG_W-1];
        end
        z_o = {folded, {ZG{1'b0}}};
    end
endmodule

// File: rtl/sincos_angle_rom.sv
// Elementary rotation angles arctan(2^-i) in binary-angle units of width ZW.
module sincos_angle_rom #(
    parameter int ZW   = 18,
    parameter int ITER = 16,
    localparam int CW  = $clog2(ITER + 1)
) (
    input  logic [CW-1:0] idx_i,
    output logic [ZW-1:0] step_o
);
    import sincos_pkg::*;

    function automatic logic [ZW-1:0] atan_units(input int k);
        real r;
        r = $atan(2.0 ** (-k)) * (2.0 ** ZW) / TWO_PI;
        return ZW'($rtoi(r + 0.5));
    endfunction

    logic [ZW-1:0] table_q [ITER];

    for (genvar g = 0; g < ITER; g++) begin : g_entry
        localparam logic [ZW-1:0] ENTRY = atan_units(g);
        assign table_q[g] = ENTRY;
    end

    always_comb begin
        step_o = '0;
        for (int k = 0; k < ITER; k++) begin
            if (idx_i == CW'(k)) step_o = table_q[k];
        end
    end
endmodule

// File: rtl/sincos_microstep.sv
// One CORDIC rotation step. Both x and y updates use the values from before the step.
module sincos_microstep #(
    parameter int IW = 18,
    parameter int ZW = 18,
    parameter int CW = 5
) (
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    input  logic [CW-1:0]        sh_i,
    input  logic [ZW-1:0]        step_i,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    logic signed [IW-1:0] xs, ys;
    logic                 neg_dir;

    always_comb begin
        xs      = x_i >>> sh_i;
        ys      = y_i >>> sh_i;
        neg_dir = z_i[ZW-1];
        if (neg_dir) begin
            x_o = x_i + ys;
            y_o = y_i - xs;
            z_o = z_i + $signed(step_i);
        end else begin
            x_o = x_i - ys;
            y_o = y_i + xs;
            z_o = z_i - $signed(step_i);
        end
    end
endmodule

// File: rtl/sincos_rotator.sv
module sincos_rotator #(
    parameter int ANG_W = 16,
    parameter int OUT_W = 16,
    parameter int GUARD = 2,
    parameter int ZG    = 2,
    parameter int ITER  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ANG_W-1:0] angle_i,
    output logic             done_o,
    output logic [OUT_W-1:0] cos_o,
    output logic [OUT_W-1:0] sin_o
);
    import sincos_pkg::*;

    localparam int IW     = OUT_W + GUARD;
    localparam int ZW     = ANG_W + ZG;
    localparam int CW     = $clog2(ITER + 1);
    localparam int FRAC_I = OUT_W - 2 + GUARD;
    localparam logic signed [IW-1:0] K_INIT =
        IW'($rtoi(ROT_GAIN * (2.0 ** FRAC_I) + 0.5));
    localparam logic signed [IW-1:0] HALF_LSB = IW'(1 << (GUARD - 1));

    phase_t state_q, state_d;

    logic signed [IW-1:0] x_q, y_q, x_n, y_n, x_rnd, y_rnd;
    logic signed [ZW-1:0] z_q, z_n, z_start;
    logic [CW-1:0]        cnt_q;
    logic [ZW-1:0]        step_ang;
    logic                 flip;
    logic                 last_step;

    sincos_fold #(.ANG_W(ANG_W), .ZG(ZG)) u_fold (
        .angle_i (angle_i),
        .z_o     (z_start),
        .flip_o  (flip)
    );

    sincos_angle_rom #(.ZW(ZW), .ITER(ITER)) u_rom (
        .idx_i  (cnt_q),
        .step_o (step_ang)
    );

    sincos_microstep #(.IW(IW), .ZW(ZW), .CW(CW)) u_step (
        .x_i    (x_q),
        .y_i    (y_q),
        .z_i    (z_q),
        .sh_i   (cnt_q),
        .step_i (step_ang),
        .x_o    (x_n),
        .y_o    (y_n),
        .z_o    (z_n)
    );

    assign last_step = (cnt_q == CW'(ITER - 1));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ROTATE;
            ST_ROTATE: if (last_step) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath: load the (possibly negated) pre-scaled vector, then rotate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            y_q   <= '0;
            z_q   <= '0;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    x_q   <= flip ? -K_INIT : K_INIT;
                    y_q   <= '0;
                    z_q   <= z_start;
                    cnt_q <= '0;
                end
                ST_ROTATE: begin
                    x_q   <= x_n;
                    y_q   <= y_n;
                    z_q   <= z_n;
                    cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Round half up by dropping the guard bits.
    always_comb begin
        x_rnd = x_q + HALF_LSB;
        y_rnd = y_q + HALF_LSB;
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            cos_o  <= '0;
            sin_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (state_q == ST_FINISH) begin
                done_o <= 1'b1;
                cos_o  <= x_rnd[IW-1 -: OUT_W];
                sin_o  <= y_rnd[IW-1 -: OUT_W];
            end
        end
    end
endmodule

// File: rtl/sincos_rotator_chk.sv
module sincos_rotator_chk #(
    parameter int OUT_W = 16,
    parameter int ITER  = 16,
    localparam int TW   = $clog2(ITER + 2) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             done_o,
    input logic [OUT_W-1:0] cos_o,
    input logic [OUT_W-1:0] sin_o
);
    localparam logic signed [OUT_W-1:0] LIM = OUT_W'((1 << (OUT_W - 2)) + 8);

    logic          run_q;
    logic [TW-1:0] age_q;
    logic          take;

    // A start is taken when idle, or in the cycle done_o is high.
    assign take = start_i && (!run_q || done_o);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            age_q <= '0;
        end else if (take) begin
            run_q <= 1'b1;
            age_q <= '0;
        end else if (done_o) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            age_q <= age_q + 1'b1;
        end
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_q && age_q == TW'(ITER + 1)));                        // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                 // R7

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(cos_o) && $stable(sin_o)));                     // R6

    AST_SINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($signed(sin_o) <= LIM && $signed(sin_o) >= -LIM));       // R3
endmodule

bind sincos_rotator sincos_rotator_chk #(.OUT_W(OUT_W), .ITER(ITER)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .done_o  (done_o),
    .cos_o   (cos_o),
    .sin_o   (sin_o)
);

// File: tb/sincos_rotator_test.sv
module sincos_rotator_test;
    localparam int  CLK_PERIOD = 10;
    localparam int  ITER       = 16;
    localparam int  TOL        = 4;
    localparam real PI2        = 6.283185307179586;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] angle_i = '0;
    logic        done_o;
    logic [15:0] cos_o, sin_o;

    int errors = 0;
    int checks = 0;

    // Reference model state
    bit          pending = 0;
    bit          ignored = 0;
    int          left = 0;
    int          exp_ang = 0;
    logic [15:0] held_c = '0, held_s = '0;

    sincos_rotator uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .angle_i (angle_i),
        .done_o  (done_o),
        .cos_o   (cos_o),
        .sin_o   (sin_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_val(input int ang, input bit sine);
        real th = $itor(ang) * PI2 / 65536.0;
        real v  = sine ? $sin(th) : $cos(th);
        return $rtoi($floor(v * 16384.0 + 0.5));
    endfunction

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // Drive one cycle of stimulus, then compare at the following falling edge.
    task automatic cycle(input bit st, input int ang);
        bit    exp_done;
        int    ec, es;
        string tag;
        start_i = st;
        angle_i = 16'(ang);
        if (st && pending) ignored = 1;
        if (st && !pending) begin
            pending = 1;
            left    = ITER + 2;
            exp_ang = ang;
        end
        @(negedge clk);
        if (pending) left--;
        exp_done = pending && (left == 0);
        check(done_o == exp_done, "R2/R7 done timing", int'(done_o), int'(exp_done));
        if (exp_done) begin
            ec = ref_val(exp_ang, 1'b0);
            es = ref_val(exp_ang, 1'b1);
            if (ignored) tag = "R5 result after ignored start";
            else if (exp_ang[15] ^ exp_ang[14]) tag = "R4 folded angle";
            else tag = "R3 value";
            check(absd(int'($signed(cos_o)), ec) <= TOL, {tag, " cos"}, int'($signed(cos_o)), ec);
            check(absd(int'($signed(sin_o)), es) <= TOL, {tag, " sin"}, int'($signed(sin_o)), es);
            held_c  = cos_o;
            held_s  = sin_o;
            pending = 0;
            ignored = 0;
        end else begin
            check(cos_o == held_c && sin_o == held_s, "R6 outputs held",
                  int'($signed(cos_o)), int'($signed(held_c)));
        end
    endtask

    task automatic run_one(input int ang, input int gap);
        cycle(1'b1, ang);
        while (pending) cycle(1'b0, 0);
        repeat (gap) cycle(1'b0, 0);
    endtask

    initial begin
        int specials [18] = '{0, 16384, -16384, -32768, 16383, 16385, -16383, -16385,
                              32767, 8192, -8192, 1, -1, 24576, -24576, 4096, 30000, -30000};
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
        check(cos_o == '0 && sin_o == '0, "R1 reset outputs", int'(cos_o), 0);
        rst_n = 1'b1;
        repeat (2) cycle(1'b0, 0);
        check(cos_o == '0 && sin_o == '0, "R1 outputs before first result", int'(sin_o), 0);

        // R3/R4: boundary angles, with the idle gap varied
        foreach (specials[k]) run_one(specials[k], k % 3);

        // R8: back-to-back starts in the done cycle
        run_one(5000, 0);
        run_one(-20000, 0);
        run_one(20000, 2);

        // R5: starts while busy are ignored
        cycle(1'b1, 12000);
        repeat (4) cycle(1'b0, 0);
        cycle(1'b1, -7000);
        cycle(1'b1, 100);
        while (pending) cycle(1'b0, 0);
        cycle(1'b0, 0);

        // Sweep the whole turn
        for (int a = -32768; a < 32768; a += 1021) run_one(a, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule